// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit

This block is a timer with eight output compare channels that share one free-running 16-bit counter. Each channel holds a 16-bit compare value, a select bit that marks it as an output compare channel (1) or an input capture channel (0), and a 2-bit pin action. When the counter reaches a channel's compare value, the block applies that channel's action to its timer pin and raises its interrupt flag. Software can also start a channel's action through a write-only force register. A forced action never sets a flag.

Channel 7 has an extra role. When its compare fires, either by a real match or by a force, the block copies bits of a channel 7 data register onto a selected set of pins. A channel 7 mask register picks those pins. On the pins it selects, this copy overrides the actions of all the other channels in that cycle.

Registers sit behind a simple port: a single-cycle write strobe plus a combinational read. Register addresses: 0 select, 1 force, 2 channel 7 mask, 3 channel 7 data, 4 actions, 5 flags, 6 interrupt enable, 7 counter (read only), 8 + x compare value of channel x.

Top module: `cmp8_top`

## Requirements
- R1: The counter resets to 0 and goes up by one on every clock edge. It wraps modulo 2^16, and address 7 reads its current value.
- R2: On each clock edge where the counter equals the compare value of an output compare channel x, the block applies the action code in bits [2x+1:2x] of the action register to pin x. The codes are 00 hold, 01 toggle, 10 drive low and 11 drive high. The new pin value is visible right after that edge. With no event, pins keep their value.
- R3: A real match on output compare channel x sets flag bit x. Writing 1 to bit x of the flag register (address 5) clears it, and writing 0 has no effect. If a set and a clear land on the same edge, the set wins.
- R4: `irq` is high exactly when some flag bit and its enable bit (address 6) are both 1.
- R5: Writing 1 to bit x of the force register (address 1) applies channel x's action on that write's clock edge. It does not set flag x.
- R6: When a force and a real match hit the same channel on the same edge, the action is applied once and the flag stays clear.
- R7: The force register always reads back as 0.
- R8: When channel 7 has a match or a force, each pin x whose mask bit (address 2) is 1 takes bit x of the data register (address 3). This overrides that pin's own action on the same edge. Flags of the other channels that match on that edge are still set.
- R9: On a channel 7 event, no data is copied to pin x if mask bit x is 0 or if channel x is an input capture channel. Such a pin follows only its own action.
- R10: An input capture channel (select bit 0 at address 0) has its output enable low. Its pin never changes, and its flag is never set by this block.
- R11: After reset, pins, output enables, flags, `irq` and all registers are 0.
- R12: The channel 7 mask register can be written and read back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 4 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| pinOut | output | 8 | Timer pin values |
| pinOe | output | 8 | Per-pin output enable (1 = output compare channel) |
| flagOut | output | 8 | Interrupt flags |
| irq | output | 1 | Enabled interrupt request |

## Verification
The hardest case to produce from the ports is a collision inside one exact cycle. One such case is a force write that lands on the very edge where the same channel's compare matches. Another is channel 7 firing on the same edge as another channel whose pin it masks. The bench reads the counter, programs a compare value a few counts ahead, then polls the counter every falling edge. When the counter reaches the target, it drives the colliding write into that same cycle. A near-exhaustive sweep runs every action code on every channel in turn, and the expected pin and flag vectors are computed in the bench.

// File: rtl/cmp8_pkg.sv
package cmp8_pkg;
  localparam int CH_N   = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = $clog2(CH_N);

  localparam logic [ADDR_W-1:0] A_SEL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_FORCE = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ACT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd7;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } actCode_t;

  typedef struct packed {
    logic [CH_N-1:0] forceHit;
    logic [CH_N-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/cmp8_ctrl.sv
module cmp8_ctrl
  import cmp8_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWe,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [CNT_W-1:0]                regWdata,
  output logic [CNT_W-1:0]                regRdata,
  input  logic [CNT_W-1:0]                cntVal,
  input  logic [CH_N-1:0]                 flagVal,
  output strobe_t                         strb,
  output logic [CH_N-1:0]                 ioSel,
  output logic [CH_N-1:0]                 ocMask,
  output logic [CH_N-1:0]                 ocData,
  output logic [2*CH_N-1:0]               actVec,
  output logic [CH_N-1:0]                 intEn,
  output logic [CH_N-1:0][CNT_W-1:0]      cmpVec
);
  localparam int PAD_W = CNT_W - CH_N;
  localparam int ACT_PAD = CNT_W - 2*CH_N;

  logic cmpSpace;
  assign cmpSpace = regAddr[ADDR_W-1];

  // one-cycle strobes toward the datapath
  always_comb begin
    strb.forceHit = '0;
    strb.flagClr  = '0;
    if (regWe && regAddr == A_FORCE) strb.forceHit = regWdata[CH_N-1:0];
    if (regWe && regAddr == A_FLAG)  strb.flagClr  = regWdata[CH_N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioSel  <= '0;
      ocMask <= '0;
      ocData <= '0;
      actVec <= '0;
      intEn  <= '0;
    end else if (regWe && !cmpSpace) begin
      case (regAddr)
        A_SEL:  ioSel  <= regWdata[CH_N-1:0];
        A_MASK: ocMask <= regWdata[CH_N-1:0];
        A_DATA: ocData <= regWdata[CH_N-1:0];
        A_ACT:  actVec <= regWdata[2*CH_N-1:0];
        A_IEN:  intEn  <= regWdata[CH_N-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : gCmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cmpVec[g] <= '0;
      else if (regWe && cmpSpace && regAddr[IDX_W-1:0] == IDX_W'(g))
        cmpVec[g] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (cmpSpace) begin
      regRdata = cmpVec[regAddr[IDX_W-1:0]];
    end else begin
      case (regAddr)
        A_SEL:   regRdata = {{PAD_W{1'b0}}, ioSel};
        A_MASK:  regRdata = {{PAD_W{1'b0}}, ocMask};
        A_DATA:  regRdata = {{PAD_W{1'b0}}, ocData};
        A_ACT:   regRdata = {{ACT_PAD{1'b0}}, actVec};
        A_FLAG:  regRdata = {{PAD_W{1'b0}}, flagVal};
        A_IEN:   regRdata = {{PAD_W{1'b0}}, intEn};
        A_CNT:   regRdata = cntVal;
        default: regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp8_dpath.sv
module cmp8_dpath
  import cmp8_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [CH_N-1:0]            ioSel,
  input  logic [CH_N-1:0]            ocMask,
  input  logic [CH_N-1:0]            ocData,
  input  logic [2*CH_N-1:0]          actVec,
  input  logic [CH_N-1:0]            intEn,
  input  logic [CH_N-1:0][CNT_W-1:0] cmpVec,
  output logic [CNT_W-1:0]           cntVal,
  output logic [CH_N-1:0]            flagVal,
  output logic [CH_N-1:0]            pinVal,
  output logic                       irq
);
  logic [CNT_W-1:0] cntQ;
  logic [CH_N-1:0]  pinQ, flagQ;
  logic [CH_N-1:0]  hit, evt, actRes, ovr, pinNext, flagNext;
  logic             ch7Evt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntQ + 1'b1;
  end

  for (genvar g = 0; g < CH_N; g++) begin : gCh
    logic res;
    assign hit[g] = ioSel[g] && (cntQ == cmpVec[g]);
    always_comb begin
      case (actCode_t'(actVec[2*g +: 2]))
        ACT_TOGGLE: res = ~pinQ[g];
        ACT_LOW:    res = 1'b0;
        ACT_HIGH:   res = 1'b1;
        default:    res = pinQ[g];
      endcase
    end
    assign actRes[g] = res;
  end

  assign evt      = ioSel & (hit | strb.forceHit);
  assign ch7Evt   = evt[CH_N-1];
  assign ovr      = {CH_N{ch7Evt}} & ocMask & ioSel;
  assign pinNext  = (ovr & ocData) | (~ovr & evt & actRes) | (~ovr & ~evt & pinQ);
  assign flagNext = (flagQ & ~strb.flagClr) | (hit & ~strb.forceHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ  <= '0;
      flagQ <= '0;
    end else begin
      pinQ  <= pinNext;
      flagQ <= flagNext;
    end
  end

  assign cntVal  = cntQ;
  assign flagVal = flagQ;
  assign pinVal  = pinQ;
  assign irq     = |(flagQ & intEn);

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.forceHit & ~flagQ) != '0) |=> ((flagQ & $past(strb.forceHit & ~flagQ)) == '0)); // R5
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((hit & ~strb.forceHit) != '0) |=> ((flagQ & $past(hit & ~strb.forceHit)) == $past(hit & ~strb.forceHit))); // R3
  AST_CH7_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    ch7Evt |=> (((pinQ ^ $past(ocData)) & $past(ocMask & ioSel)) == '0)); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evt == '0) |=> $stable(pinQ)); // R2
  AST_IC_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((~ioSel & ~flagQ) != '0) |=> ((flagQ & $past(~ioSel & ~flagQ)) == '0)); // R10
endmodule

// File: rtl/cmp8_top.sv
module cmp8_top
  import cmp8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic [CH_N-1:0]   pinOut,
  output logic [CH_N-1:0]   pinOe,
  output logic [CH_N-1:0]   flagOut,
  output logic              irq
);
  strobe_t                    strb;
  logic [CH_N-1:0]            ioSel, ocMask, ocData, intEn, flagVal;
  logic [2*CH_N-1:0]          actVec;
  logic [CH_N-1:0][CNT_W-1:0] cmpVec;
  logic [CNT_W-1:0]           cntVal;

  cmp8_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cntVal(cntVal),
    .flagVal(flagVal), .strb(strb), .ioSel(ioSel), .ocMask(ocMask),
    .ocData(ocData), .actVec(actVec), .intEn(intEn), .cmpVec(cmpVec)
  );

  cmp8_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ioSel(ioSel), .ocMask(ocMask),
    .ocData(ocData), .actVec(actVec), .intEn(intEn), .cmpVec(cmpVec),
    .cntVal(cntVal), .flagVal(flagVal), .pinVal(pinOut), .irq(irq)
  );

  assign pinOe   = ioSel;
  assign flagOut = flagVal;
endmodule

// File: tb/sim_cmp8_top.sv
`timescale 1ns/1ps
module sim_cmp8_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [7:0]  pinOut, pinOe, flagOut;
  logic        irq;
  int          testCnt = 0;
  int          failCnt = 0;
  bit          done = 1'b0;
  logic [7:0]  expPin = '0;
  logic [7:0]  expFlag = '0;
  logic [15:0] actSh = '0;
  logic [15:0] v, t;

  always #2 clk = ~clk;

  cmp8_top u0 (.clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinOut(pinOut), .pinOe(pinOe),
    .flagOut(flagOut), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk); #0.5;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regWe = 1'b0; regAddr = a;
    #0.5 d = regRdata;
  endtask

  // returns half a cycle before the edge on which the counter equals tgt
  task automatic waitCnt(input logic [15:0] tgt);
    logic [15:0] c;
    do rd(4'd7, c); while (c != tgt);
  endtask

  // same-cycle write, driven inside the cycle left by waitCnt
  task automatic hitWrite(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk); #0.5;
    regWe = 1'b0;
  endtask

  function automatic logic apply(input logic [1:0] code, input logic cur);
    case (code)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 pins", pinOut, 0);
    chk("R11 oe", pinOe, 0);
    chk("R11 flags", flagOut, 0);
    chk("R11 irq", irq, 0);
    @(negedge clk); rstN = 1'b1;
    rd(4'd7, v); chk("R1 count after reset", v, 1);
    rd(4'd7, v); chk("R1 increment", v, 2);
    rd(4'd2, v); chk("R11 mask reset", v, 0);

    // R2/R3 sweep: every action code on channels 0..6
    wr(4'd0, 16'h007F);
    chk("R10 oe", pinOe, 8'h7F);
    for (int ch = 0; ch < 7; ch++) begin
      for (int code = 0; code < 4; code++) begin
        actSh[2*ch +: 2] = code[1:0];
        wr(4'd4, actSh);
        rd(4'd7, v); t = v + 16'd8;
        wr(4'(8 + ch), t);
        waitCnt(t);
        @(posedge clk); #1;
        expPin[ch] = apply(code[1:0], expPin[ch]);
        expFlag[ch] = 1'b1;
        chk("R2 match action", pinOut, expPin);
        chk("R3 match flag", flagOut, expFlag);
        wr(4'd5, 16'(1 << ch));
        expFlag[ch] = 1'b0;
        chk("R3 clear", flagOut, expFlag);
      end
    end

    // R4 interrupt gating
    wr(4'd6, 16'h0004);
    rd(4'd7, v); t = v + 16'd6;
    wr(4'd10, t); waitCnt(t); @(posedge clk); #1;
    expFlag[2] = 1'b1; expPin[2] = apply(actSh[5:4], expPin[2]);
    chk("R4 irq on", irq, 1);
    wr(4'd5, 16'h0004); expFlag[2] = 1'b0;
    chk("R4 irq off", irq, 0);

    // R3: set wins over same-cycle clear; writing 0 does nothing
    rd(4'd7, v); t = v + 16'd6;
    wr(4'd12, t); waitCnt(t);
    hitWrite(4'd5, 16'h0010);
    expFlag[4] = 1'b1; expPin[4] = apply(actSh[9:8], expPin[4]);
    chk("R3 set beats clear", flagOut, expFlag);
    wr(4'd5, 16'h0000);
    chk("R3 write zero", flagOut, expFlag);
    wr(4'd5, 16'h0010); expFlag[4] = 1'b0;
    chk("R3 clear again", flagOut, expFlag);

    // R5 force sweep: toggle on every channel
    wr(4'd0, 16'h00FF);
    actSh = 16'h5555; wr(4'd4, actSh);
    for (int ch = 0; ch < 8; ch++) begin
      wr(4'd1, 16'(1 << ch));
      expPin[ch] = ~expPin[ch];
      chk("R5 force pin", pinOut, expPin);
      chk("R5 force no flag", flagOut, expFlag);
    end
    rd(4'd1, v); chk("R7 force reads zero", v, 0);
    wr(4'd2, 16'h005A); rd(4'd2, v); chk("R12 mask readback", v, 16'h005A);
    wr(4'd2, 16'h0000);

    // R6 force and match on the same edge
    rd(4'd7, v); t = v + 16'd6;
    wr(4'd11, t); waitCnt(t);
    hitWrite(4'd1, 16'h0008);
    expPin[3] = ~expPin[3];
    chk("R6 single toggle", pinOut, expPin);
    chk("R6 no flag", flagOut, expFlag);

    // R8/R9/R10 channel 7 override, channel 5 input capture
    wr(4'd0, 16'h00DF);
    chk("R10 oe ic", pinOe, 8'hDF);
    wr(4'd2, 16'h002F);
    wr(4'd3, 16'h00A4);
    actSh = 16'h400C; wr(4'd4, actSh);   // ch1 high, ch7 toggle
    rd(4'd7, v); t = v + 16'd9;
    wr(4'd9, t); wr(4'd15, t); wr(4'd13, t);
    waitCnt(t);
    @(posedge clk); #1;
    expPin[3:0] = 4'h4;                 // data bits override, incl. ch1 high
    expPin[7] = ~expPin[7];             // mask7 is 0: own toggle
    expFlag[1] = 1'b1; expFlag[7] = 1'b1;
    chk("R8 override pins", pinOut & 8'h0F, expPin & 8'h0F);
    chk("R9 unmasked and ic pins", pinOut & 8'hF0, expPin & 8'hF0);
    chk("R8 flags still set", flagOut & 8'h82, 8'h82);
    chk("R10 ic no flag", flagOut & 8'h20, 8'h00);
    wr(4'd5, 16'h00FF); expFlag = '0;
    wr(4'd2, 16'h000F); wr(4'd3, 16'h000F);
    wr(4'd1, 16'h0080);
    expPin[3:0] = 4'hF; expPin[7] = ~expPin[7];
    chk("R8 forced ch7 override", pinOut, expPin);
    chk("R5 forced ch7 no flag", flagOut, expFlag);
    wr(4'd1, 16'h0020);
    chk("R10 ic force ignored", pinOut, expPin);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule